// File: doc/BRIEF.md
# Priority Interrupt Controller with Claim and Completion

This block gathers 32 external interrupt sources for one processor core. Each source has a 3-bit priority and an enable bit. A source that is high while enabled records a pending event. An arbiter picks the most urgent pending source, and the block hands that source's number to the core as the claimed interrupt. The block then raises a single interrupt line and keeps it raised until the core reports, with a completion write, that it has serviced that source.

Only one claim is outstanding at any time. Other pending events stay recorded until their turn comes. Priorities are loaded as one 96-bit word and enables as one 32-bit word. Both use write-enable strobes and need no bus. Reset is asynchronous and active-low, and an internal synchronizer releases it on a clock edge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is low, `core_irq_o` is 0 and `claim_id_o` is 0. Priorities, enables and pending bits are cleared, so after release no source is selected until it is configured.
- R2: When `prio_we` is high at a clock edge, all 32 priorities are replaced at once from `prio_wdata`. Source i takes bits [3i+2:3i]. When `en_we` is high, all 32 enables are replaced from `en_wdata`, and bit i enables source i. Either write takes effect for selection from the next cycle on.
- R3: A source whose enable bit is 0 is ignored. An input pulse on it sets no pending bit, so enabling it later raises no interrupt.
- R4: A source that is high at a clock edge while enabled becomes pending. Among the pending, enabled sources with a nonzero priority, the one with the largest priority value is selected.
- R5: A source with priority 0 is never selected. Its pending bit is kept, so it is selected once it is given a nonzero priority.
- R6: When several candidates share the highest priority, the lowest-numbered one wins.
- R7: A source that becomes pending at edge E, with no claim outstanding, appears on `claim_id_o` after edge E+1. `core_irq_o` rises after edge E+2, one cycle after the claim becomes active.
- R8: While a claim is outstanding, `claim_id_o` holds and no other source is claimed. Other pending sources keep their pending bits and are claimed, in priority order, after completion.
- R9: A completion (`done_we` high with `done_id_i` equal to `claim_id_o`) ends the claim at that edge. `core_irq_o` falls one edge later. A further pending source may be claimed at that same later edge.
- R10: A completion whose `done_id_i` differs from the claimed ID is ignored. The claim and `core_irq_o` stay as they are.
- R11: If a completion and a new source event arrive at the same edge, the event is still latched and is claimed afterwards.
- R12: A pending source whose enable is cleared is not selected while disabled. It keeps its pending bit and is claimed once it is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | External source lines, one per source |
| prio_wdata | input | 96 | New priority word, 3 bits per source |
| prio_we | input | 1 | Load all priorities |
| en_wdata | input | 32 | New enable word |
| en_we | input | 1 | Load all enables |
| done_id_i | input | 5 | ID of the source being completed |
| done_we | input | 1 | Completion strobe |
| core_irq_o | output | 1 | Interrupt line to the core |
| claim_id_o | output | 5 | ID of the currently claimed source |

## Verification
Two pairs of functions can meet in the same cycle.

The first pair is a completion and a fresh source event. The bench drives the completion strobe and a pulse on another source on the same edge. It then judges that the pulsed source is claimed at the next edge, after `core_irq_o` has dipped low for exactly one cycle.

The second pair is a completion and the claim of a source that was already pending. Here the bench checks that the waiting source appears on `claim_id_o` one edge after the completion, without waiting for `core_irq_o`.

A behavioural model in the bench predicts both outputs on every clock. Directed checks pin the expected IDs at the boundaries: ties, priority zero and disabled sources.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NSRC_DEF   = 32;
  localparam int PRIO_W_DEF = 3;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] take_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] pend_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    // a new qualified event wins over a clear in the same cycle
    always_comb pend_d[g] = (pend_q[g] & ~take_i[g]) | (src_i[g] & en_i[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter  int NSRC   = 32,
  parameter  int PRIO_W = 3,
  localparam int ID_W   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        cand_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output logic                   win_vld_o,
  output logic [ID_W-1:0]        win_id_o
);
  logic [PRIO_W-1:0] best;
  logic [ID_W-1:0]   best_id;

  always_comb begin
    best    = '0;
    best_id = '0;
    // strict compare keeps the lowest index on ties; priority 0 never wins
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        best    = prio_i[i*PRIO_W +: PRIO_W];
        best_id = ID_W'(i);
      end
    end
  end

  assign win_vld_o = (best != '0);
  assign win_id_o  = best_id;
endmodule

// File: rtl/irq_claim_unit.sv
module irq_claim_unit #(
  parameter  int NSRC = 32,
  localparam int ID_W = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_vld_i,
  input  logic [ID_W-1:0] win_id_i,
  input  logic            done_we_i,
  input  logic [ID_W-1:0] done_id_i,
  output logic [NSRC-1:0] take_o,
  output logic            active_o,
  output logic [ID_W-1:0] claim_id_o,
  output logic            irq_o
);
  logic            active_q, active_d;
  logic [ID_W-1:0] id_q, id_d;
  logic            irq_q;
  logic            grant;
  logic            done_hit;

  always_comb begin
    done_hit = active_q && done_we_i && (done_id_i == id_q);
    grant    = !active_q && win_vld_i;
    active_d = active_q;
    id_d     = id_q;
    if (done_hit) active_d = 1'b0;
    if (grant) begin
      active_d = 1'b1;
      id_d     = win_id_i;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_take
    assign take_o[g] = grant && (win_id_i == ID_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      id_q     <= '0;
      irq_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      id_q     <= id_d;
      irq_q    <= active_q;
    end
  end

  assign active_o   = active_q;
  assign claim_id_o = id_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter  int NSRC   = irq_prio_pkg::NSRC_DEF,
  parameter  int PRIO_W = irq_prio_pkg::PRIO_W_DEF,
  localparam int ID_W   = $clog2(NSRC),
  localparam int PV_W   = NSRC * PRIO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src_i,
  input  logic [PV_W-1:0] prio_wdata,
  input  logic            prio_we,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            en_we,
  input  logic [ID_W-1:0] done_id_i,
  input  logic            done_we,
  output logic            core_irq_o,
  output logic [ID_W-1:0] claim_id_o
);
  logic            rst_int_n;
  logic [PV_W-1:0] prio_q, prio_d;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] take;
  logic            win_vld;
  logic [ID_W-1:0] win_id;
  logic            claim_active;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    prio_d = prio_we ? prio_wdata : prio_q;
    en_d   = en_we   ? en_wdata   : en_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prio_q <= '0;
      en_q   <= '0;
    end else begin
      prio_q <= prio_d;
      en_q   <= en_d;
    end
  end

  irq_pend_latch #(.NSRC(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .src_i  (irq_src_i),
    .en_i   (en_q),
    .take_i (take),
    .pend_o (pend)
  );

  irq_prio_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .cand_i    (pend & en_q),
    .prio_i    (prio_q),
    .win_vld_o (win_vld),
    .win_id_o  (win_id)
  );

  irq_claim_unit #(.NSRC(NSRC)) u_claim (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .win_vld_i  (win_vld),
    .win_id_i   (win_id),
    .done_we_i  (done_we),
    .done_id_i  (done_id_i),
    .take_o     (take),
    .active_o   (claim_active),
    .claim_id_o (claim_id_o),
    .irq_o      (core_irq_o)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter  int NSRC   = 32,
  parameter  int PRIO_W = 3,
  localparam int ID_W   = $clog2(NSRC)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   core_irq_o,
  input logic [ID_W-1:0]        claim_id_o,
  input logic                   done_we,
  input logic [ID_W-1:0]        done_id_i,
  input logic                   claim_active,
  input logic [NSRC*PRIO_W-1:0] prio_q
);
  logic [NSRC*PRIO_W-1:0] prio_d1;

  always_ff @(posedge clk) prio_d1 <= prio_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!core_irq_o && claim_id_o == '0); // R1
    end
  end

  AST_IRQ_FOLLOWS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    claim_active |=> core_irq_o); // R7

  AST_IRQ_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !claim_active |=> !core_irq_o); // R9

  AST_CLAIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_active && !(done_we && done_id_i == claim_id_o))
    |=> (claim_active && $stable(claim_id_o))); // R10

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_active && done_we && done_id_i == claim_id_o) |=> !claim_active); // R9

  AST_NO_ZERO_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(claim_active) |-> (prio_d1[int'(claim_id_o)*PRIO_W +: PRIO_W] != '0)); // R5
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_irq_o   (core_irq_o),
  .claim_id_o   (claim_id_o),
  .done_we      (done_we),
  .done_id_i    (done_id_i),
  .claim_active (claim_active),
  .prio_q       (prio_q)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src_i = '0;
  logic [95:0] prio_wdata = '0;
  logic        prio_we = 1'b0;
  logic [31:0] en_wdata = '0;
  logic        en_we = 1'b0;
  logic [4:0]  done_id_i = '0;
  logic        done_we = 1'b0;
  logic        core_irq_o;
  logic [4:0]  claim_id_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [95:0] prio_vec = '0;

  always #2 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i),
    .prio_wdata(prio_wdata), .prio_we(prio_we),
    .en_wdata(en_wdata), .en_we(en_we),
    .done_id_i(done_id_i), .done_we(done_we),
    .core_irq_o(core_irq_o), .claim_id_o(claim_id_o)
  );

  // behavioural reference model
  int m_prio [32];
  bit m_en   [32];
  bit m_pend [32];
  bit m_act, m_irq;
  int m_cid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_en[i] = 0; m_pend[i] = 0; end
      m_act = 0; m_irq = 0; m_cid = 0;
    end else begin
      int best, bid, take;
      bit nact;
      best = 0; bid = 0; take = -1;
      for (int i = 0; i < 32; i++)
        if (m_pend[i] && m_en[i] && m_prio[i] > best) begin best = m_prio[i]; bid = i; end
      m_irq = m_act;
      nact = m_act;
      if (m_act && done_we && int'(done_id_i) == m_cid) nact = 0;
      if (!m_act && best > 0) begin nact = 1; m_cid = bid; take = bid; end
      for (int i = 0; i < 32; i++)
        m_pend[i] = (m_pend[i] && i != take) || (irq_src_i[i] && m_en[i]);
      m_act = nact;
      if (prio_we) for (int i = 0; i < 32; i++) m_prio[i] = int'(prio_wdata[i*3 +: 3]);
      if (en_we)   for (int i = 0; i < 32; i++) m_en[i] = en_wdata[i];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R8 ordering, R4 selection)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(core_irq_o == m_irq, "R8 model irq", int'(core_irq_o), int'(m_irq));
      chk(int'(claim_id_o) == m_cid, "R4 model claim", int'(claim_id_o), m_cid);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse(input logic [31:0] m);
    irq_src_i = m; @(negedge clk); irq_src_i = '0;
  endtask
  task automatic done(input int id);
    done_we = 1'b1; done_id_i = 5'(id); @(negedge clk); done_we = 1'b0;
  endtask
  task automatic set_en(input logic [31:0] m);
    en_wdata = m; en_we = 1'b1; @(negedge clk); en_we = 1'b0;
  endtask
  task automatic put_prio(input int idx, input int v);
    prio_vec[idx*3 +: 3] = 3'(v);
    prio_wdata = prio_vec; prio_we = 1'b1; @(negedge clk); prio_we = 1'b0;
  endtask
  task automatic expect_out(input int irq, input int id, input string req);
    chk(int'(core_irq_o) == irq, req, int'(core_irq_o), irq);
    if (id >= 0) chk(int'(claim_id_o) == id, req, int'(claim_id_o), id);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_out(0, 0, "R1 reset");
    rst_n = 1'b1;
    step(4);
    expect_out(0, 0, "R1 after release");
    set_en('1);
    put_prio(5, 3); put_prio(9, 7); put_prio(12, 7);

    // R4 / R7: two sources, higher priority claimed, irq one cycle later
    pulse(32'h0000_0220);
    step(1); expect_out(0, 9, "R7 claim first");
    step(1); expect_out(1, 9, "R4 highest wins");
    step(3); expect_out(1, 9, "R8 claim held");
    done(5);
    step(2); expect_out(1, 9, "R10 mismatch ignored");
    done(9);
    step(1); expect_out(0, 5, "R9 completion and next claim");
    step(1); expect_out(1, 5, "R8 waiting source kept");
    done(5);
    step(3); expect_out(0, -1, "R9 irq drops");

    // R6 tie on priority 7
    pulse(32'h0000_1200);
    step(2); expect_out(1, 9, "R6 lowest index");
    done(9);
    step(2); expect_out(1, 12, "R6 second of tie");
    done(12); step(3);

    // R5 priority 0
    pulse(32'h0000_0008);
    step(4); expect_out(0, -1, "R5 zero never selected");
    put_prio(3, 2);
    step(2); expect_out(1, 3, "R5 kept pending");
    done(3); step(3);

    // R3 disabled source ignored
    set_en(32'hFFEF_FFFF);
    put_prio(20, 5);
    pulse(32'h0010_0000);
    step(4); expect_out(0, -1, "R3 disabled ignored");
    set_en('1);
    step(4); expect_out(0, -1, "R3 no latched event");

    // R12 enable cleared while pending
    pulse(32'h0000_0200);
    step(2); expect_out(1, 9, "R12 setup");
    pulse(32'h0000_0020);
    set_en(32'hFFFF_FFDF);
    done(9);
    step(4); expect_out(0, -1, "R12 masked");
    set_en('1);
    step(3); expect_out(1, 5, "R12 re-enabled");
    done(5); step(3);

    // R11 completion and new event together
    pulse(32'h0000_1000);
    step(2); expect_out(1, 12, "R11 setup");
    done_we = 1'b1; done_id_i = 5'd12; irq_src_i = 32'h0000_0020;
    @(negedge clk);
    done_we = 1'b0; irq_src_i = '0;
    step(1); expect_out(0, 5, "R11 event latched");
    step(1); expect_out(1, 5, "R11 irq back");
    done(5); step(3);

    // R2 whole-vector write, top fields
    prio_vec[93 +: 3] = 3'd7; prio_vec[90 +: 3] = 3'd6;
    prio_wdata = prio_vec; prio_we = 1'b1; @(negedge clk); prio_we = 1'b0;
    pulse(32'hC000_0000);
    step(2); expect_out(1, 31, "R2 top field");
    done(31);
    step(2); expect_out(1, 30, "R2 next field");
    done(30); step(3);
    expect_out(0, -1, "R9 idle at end");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule